// File: doc/BRIEF.md
# Paired PC and Constant-Base Sequencer

This block is the control-flow core of a small 16-bit-packet processor whose program carries its constants in a separate block of 64-bit words. It owns three registers:

- the program counter,
- the constant base, which marks where the current constant block starts,
- a link register holding two packed 32-bit relative offsets rather than a return address.

It accepts one decoded control packet at a time over a valid/ready handshake. It reads constants through a one-cycle-latency memory port and moves the program counter and the constant base, alone or together.

Plain jumps and conditional branches move the program counter by a packet-relative offset. A block-link packet adds a 64-bit constant to the constant base. A call adds a two-lane constant to the (pc, base) pair and records that same pair in the link register. A return adds a two-lane constant and subtracts the recorded pair. A pack packet forms the link register from two register operands, measured against the current pc and base.

Fetch, the arithmetic datapath and data memory sit outside the block. The block reports its register values and the constant address it is reading.

Top module: `pcib_sequencer`

## Requirements
- R1: After reset the program counter equals parameter PC_RESET, the constant base equals IB_RESET, the link register is zero, insReady is 1 and cmemRdEn is 0.
- R2: A packet is 16 bits. Bits 15:14 are a size field (00), bits 13:9 are the opcode, and bits 8:0 are operands. Operands are either imm9 in bits 8:0, or a register field in 8:6 with imm6 in 5:0, or register fields rc 8:6, rb 5:3 and ra 2:0. Opcode 00001 is jump, 00010 branch, 00100 block-link, 00101 call, 00110 return and 10100 pack.
- R3: A jump sets pc to pc + sext(imm9)*2 + 2 on the edge that accepts it, leaving base and link unchanged.
- R4: A branch behaves as a jump when condFlag is 1 at acceptance, and otherwise advances pc by 2.
- R5: Any opcode other than the six in R2 advances pc by 2 on the accepting edge, leaves base and link unchanged, and keeps insReady at 1.
- R6: For block-link, call and return, cmemRdEn is 1 for exactly the one cycle after acceptance, with cmemAddr = base + imm6*8. The constant arrives the next cycle, the registers update at the end of that cycle, and insReady is 0 in both of those cycles.
- R7: Block-link adds the 64-bit constant to the base and advances pc by 2; link is unchanged.
- R8: Call adds the constant's low 32-bit lane to pc and its high lane to the base, and writes the constant into the link register.
- R9: Return adds the constant's low lane minus the link's low lane to pc, and the constant's high lane minus the link's high lane to the base; link is unchanged.
- R10: Pack sets link to {base[31:0] - ra[31:0], pc[31:0] - rb[31:0]} (base lane high, pc lane low), and advances pc by 2 with the base unchanged.
- R11: Every 32-bit lane is sign-extended to 64 bits before it is added or subtracted, so negative lanes move pc or base backwards.
- R12: While insValid is 0, no register changes, whatever insWord holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| insValid | input | 1 | Packet present on insWord |
| insReady | output | 1 | Block can accept a packet this cycle |
| insWord | input | 16 | Control packet |
| condFlag | input | 1 | Result of the latest compare, used by branch |
| rbData | input | 64 | Register read data for operand rb |
| raData | input | 64 | Register read data for operand ra |
| cmemRdEn | output | 1 | Constant memory read strobe |
| cmemAddr | output | 64 | Constant memory byte address |
| cmemData | input | 64 | Constant read data, valid the cycle after cmemRdEn |
| pcOut | output | 64 | Program counter |
| ibOut | output | 64 | Constant base |
| linkOut | output | 64 | Link register, pc lane in bits 31:0, base lane in 63:32 |

## Verification
Jumps are tried with positive and negative imm9 values, which shows whether sign extension and the *2+2 scaling are both applied. Branches are run with the flag high and low, which separates the taken path from the fall-through path.

Constant-based packets use lanes of both signs, including a negative pc lane beside a positive base lane, which exposes swapped lanes or missing sign extension. A call followed by a return shows that the link subtraction is performed lane by lane. Idle cycles with junk on insWord, and a non-control opcode, show that nothing moves without an accepted packet.

// File: rtl/pcib_pkg.sv
package pcib_pkg;
  localparam int XLEN    = 64;
  localparam int LANE    = 32;
  localparam int PKTW    = 16;
  localparam int OPW     = 5;
  localparam int IMM9W   = 9;
  localparam int IMM6W   = 6;
  localparam int SLOTSH  = 3;           // 8-byte constant slots
  localparam int PKTBYTES = PKTW / 8;

  localparam logic [OPW-1:0] OP_J     = 5'b00001;
  localparam logic [OPW-1:0] OP_B     = 5'b00010;
  localparam logic [OPW-1:0] OP_IBL   = 5'b00100;
  localparam logic [OPW-1:0] OP_CALL  = 5'b00101;
  localparam logic [OPW-1:0] OP_RET   = 5'b00110;
  localparam logic [OPW-1:0] OP_PACK  = 5'b10100;

  typedef enum logic [2:0] {K_STEP, K_REL, K_LINKIB, K_CALL, K_RET, K_PACK} kind_e;
  typedef enum logic [1:0] {S_IDLE, S_READ, S_COMMIT} state_e;

  typedef struct packed {
    logic             upd;
    kind_e            kind;
    logic             rdEn;
    logic [IMM9W-1:0] imm9;
    logic [IMM6W-1:0] imm6;
  } strobe_t;

  function automatic logic [XLEN-1:0] sextLane(input logic [LANE-1:0] v);
    return {{(XLEN-LANE){v[LANE-1]}}, v};
  endfunction
endpackage

// File: rtl/pcib_ctrl.sv
module pcib_ctrl
  import pcib_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            insValid,
  output logic            insReady,
  input  logic [PKTW-1:0] insWord,
  input  logic            condFlag,
  output strobe_t         st
);
  state_e           state;
  kind_e            kindQ;
  kind_e            kindNow;
  logic [IMM6W-1:0] imm6Q;
  logic [OPW-1:0]   opcode;
  logic             accept;
  logic             isConst;

  assign opcode   = insWord[PKTW-3 -: OPW];
  assign insReady = (state == S_IDLE);
  assign accept   = insValid && insReady;

  always_comb begin
    unique case (opcode)
      OP_J:    kindNow = K_REL;
      OP_B:    kindNow = condFlag ? K_REL : K_STEP;
      OP_IBL:  kindNow = K_LINKIB;
      OP_CALL: kindNow = K_CALL;
      OP_RET:  kindNow = K_RET;
      OP_PACK: kindNow = K_PACK;
      default: kindNow = K_STEP;
    endcase
  end

  assign isConst = (kindNow == K_LINKIB) || (kindNow == K_CALL) || (kindNow == K_RET);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      kindQ <= K_STEP;
      imm6Q <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (accept && isConst) begin
          state <= S_READ;
          kindQ <= kindNow;
          imm6Q <= insWord[IMM6W-1:0];
        end
        S_READ:   state <= S_COMMIT;
        default:  state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    st.upd  = 1'b0;
    st.rdEn = 1'b0;
    st.kind = kindNow;
    st.imm9 = insWord[IMM9W-1:0];
    st.imm6 = imm6Q;
    unique case (state)
      S_IDLE:   st.upd = accept && !isConst;
      S_READ:   begin st.rdEn = 1'b1; st.kind = kindQ; end
      default:  begin st.upd = 1'b1;  st.kind = kindQ; end
    endcase
  end

  p_stall_r6: assert property (@(posedge clk) disable iff (!rstN)
    accept && isConst |=> st.rdEn && !insReady);
  p_rd_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    st.rdEn |=> !st.rdEn && !insReady && st.upd);
  p_resume_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_COMMIT) |=> insReady);
  p_plain_ready_r5: assert property (@(posedge clk) disable iff (!rstN)
    accept && !isConst |=> insReady);
endmodule

// File: rtl/pcib_dpath.sv
module pcib_dpath
  import pcib_pkg::*;
#(
  parameter logic [XLEN-1:0] PC_RESET = '0,
  parameter logic [XLEN-1:0] IB_RESET = '0
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         st,
  input  logic [XLEN-1:0] cmemData,
  input  logic [XLEN-1:0] rbData,
  input  logic [XLEN-1:0] raData,
  output logic [XLEN-1:0] pcQ,
  output logic [XLEN-1:0] ibQ,
  output logic [XLEN-1:0] linkQ,
  output logic [XLEN-1:0] cmemAddr
);
  logic [XLEN-1:0] pcN, ibN, linkN, relOff, cPc, cIb, lPc, lIb, stepPc;

  assign cmemAddr = ibQ + (XLEN'(st.imm6) << SLOTSH);
  assign relOff   = ({{(XLEN-IMM9W){st.imm9[IMM9W-1]}}, st.imm9} << 1) + XLEN'(PKTBYTES);
  assign stepPc   = pcQ + XLEN'(PKTBYTES);
  assign cPc      = sextLane(cmemData[LANE-1:0]);
  assign cIb      = sextLane(cmemData[XLEN-1:LANE]);
  assign lPc      = sextLane(linkQ[LANE-1:0]);
  assign lIb      = sextLane(linkQ[XLEN-1:LANE]);

  always_comb begin
    pcN   = pcQ;
    ibN   = ibQ;
    linkN = linkQ;
    unique case (st.kind)
      K_REL:    pcN = pcQ + relOff;
      K_LINKIB: begin pcN = stepPc; ibN = ibQ + cmemData; end
      K_CALL:   begin pcN = pcQ + cPc; ibN = ibQ + cIb; linkN = cmemData; end
      K_RET:    begin pcN = pcQ + cPc - lPc; ibN = ibQ + cIb - lIb; end
      K_PACK:   begin
        pcN   = stepPc;
        linkN = {ibQ[LANE-1:0] - raData[LANE-1:0], pcQ[LANE-1:0] - rbData[LANE-1:0]};
      end
      default:  pcN = stepPc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ   <= PC_RESET;
      ibQ   <= IB_RESET;
      linkQ <= '0;
    end else if (st.upd) begin
      pcQ   <= pcN;
      ibQ   <= ibN;
      linkQ <= linkN;
    end
  end

  p_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    !st.upd |=> $stable(pcQ) && $stable(ibQ) && $stable(linkQ));
  p_ib_keep_r5: assert property (@(posedge clk) disable iff (!rstN)
    st.upd && (st.kind == K_STEP || st.kind == K_REL || st.kind == K_PACK) |=> $stable(ibQ));
  p_link_call_r8: assert property (@(posedge clk) disable iff (!rstN)
    st.upd && st.kind == K_CALL |=> linkQ == $past(cmemData));
  p_ret_link_r9: assert property (@(posedge clk) disable iff (!rstN)
    st.upd && st.kind == K_RET |=> $stable(linkQ));
endmodule

// File: rtl/pcib_sequencer.sv
module pcib_sequencer
  import pcib_pkg::*;
#(
  parameter logic [63:0] PC_RESET = 64'h0000_0000_0000_1000,
  parameter logic [63:0] IB_RESET = 64'h0000_0000_0000_8000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        insValid,
  output logic        insReady,
  input  logic [15:0] insWord,
  input  logic        condFlag,
  input  logic [63:0] rbData,
  input  logic [63:0] raData,
  output logic        cmemRdEn,
  output logic [63:0] cmemAddr,
  input  logic [63:0] cmemData,
  output logic [63:0] pcOut,
  output logic [63:0] ibOut,
  output logic [63:0] linkOut
);
  strobe_t st;

  pcib_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .insValid(insValid), .insReady(insReady),
    .insWord(insWord), .condFlag(condFlag), .st(st)
  );

  pcib_dpath #(.PC_RESET(PC_RESET), .IB_RESET(IB_RESET)) u_dpath (
    .clk(clk), .rstN(rstN), .st(st), .cmemData(cmemData),
    .rbData(rbData), .raData(raData), .pcQ(pcOut), .ibQ(ibOut),
    .linkQ(linkOut), .cmemAddr(cmemAddr)
  );

  assign cmemRdEn = st.rdEn;
endmodule

// File: tb/pcib_sequencer_tb.sv
module pcib_sequencer_tb;
  localparam time CLK_PERIOD = 10;
  localparam logic [63:0] PC0 = 64'h0000_0000_0000_1000;
  localparam logic [63:0] IB0 = 64'h0000_0000_0000_8000;

  logic clk = 0, rstN = 0, insValid = 0, condFlag = 0;
  logic insReady, cmemRdEn;
  logic [15:0] insWord = '0;
  logic [63:0] rbData = '0, raData = '0, cmemData = '0, constVal = '0;
  logic [63:0] cmemAddr, pcOut, ibOut, linkOut;
  logic [63:0] expPc, expIb, expLink;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (cmemRdEn) cmemData <= constVal;

  pcib_sequencer #(.PC_RESET(PC0), .IB_RESET(IB0)) u_dut (
    .clk(clk), .rstN(rstN), .insValid(insValid), .insReady(insReady),
    .insWord(insWord), .condFlag(condFlag), .rbData(rbData), .raData(raData),
    .cmemRdEn(cmemRdEn), .cmemAddr(cmemAddr), .cmemData(cmemData),
    .pcOut(pcOut), .ibOut(ibOut), .linkOut(linkOut)
  );

  function automatic logic [63:0] sx(input logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction
  function automatic logic [15:0] mk9(input logic [4:0] op, input logic [8:0] imm);
    return {2'b00, op, imm};
  endfunction
  function automatic logic [15:0] mk6(input logic [4:0] op, input logic [5:0] imm);
    return {2'b00, op, 3'd1, imm};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chkRegs(input string req);
    chk({req, " pc"}, pcOut, expPc);
    chk({req, " ib"}, ibOut, expIb);
    chk({req, " link"}, linkOut, expLink);
  endtask

  // Drive a packet; returns at a negedge once the result is visible.
  task automatic issue(input logic [15:0] w, input bit konst, input logic [63:0] expAddr,
                       input string req);
    @(negedge clk); insValid = 1; insWord = w;
    @(negedge clk); insValid = 0; insWord = 16'hFFFF;
    if (konst) begin
      chk({req, " R6 rdEn"}, 64'(cmemRdEn), 64'd1);
      chk({req, " R6 addr"}, cmemAddr, expAddr);
      chk({req, " R6 ready low"}, 64'(insReady), 64'd0);
      @(negedge clk);
      chk({req, " R6 rdEn single"}, 64'(cmemRdEn), 64'd0);
      chk({req, " R6 ready low 2"}, 64'(insReady), 64'd0);
      @(negedge clk);
    end
    chk({req, " ready"}, 64'(insReady), 64'd1);
  endtask

  task automatic t_reset;
    chk("R1 pc", pcOut, PC0);
    chk("R1 ib", ibOut, IB0);
    chk("R1 link", linkOut, 64'd0);
    chk("R1 ready", 64'(insReady), 64'd1);
    chk("R1 rdEn", 64'(cmemRdEn), 64'd0);
    expPc = PC0; expIb = IB0; expLink = '0;
  endtask

  task automatic t_jump;
    issue(mk9(5'b00001, 9'd5), 0, '0, "R3 fwd");
    expPc = expPc + 64'd12; chkRegs("R3 fwd");
    issue(mk9(5'b00001, 9'h1FD), 0, '0, "R3 back");
    expPc = expPc - 64'd4; chkRegs("R3 back R2");
  endtask

  task automatic t_branch;
    condFlag = 1;
    issue(mk9(5'b00010, 9'd8), 0, '0, "R4 taken");
    expPc = expPc + 64'd18; chkRegs("R4 taken");
    condFlag = 0;
    issue(mk9(5'b00010, 9'd8), 0, '0, "R4 not");
    expPc = expPc + 64'd2; chkRegs("R4 not taken");
  endtask

  task automatic t_step;
    issue({2'b00, 5'b11100, 9'h1AB}, 0, '0, "R5 add");
    expPc = expPc + 64'd2; chkRegs("R5 other opcode");
  endtask

  task automatic t_ibl;
    constVal = 64'h0000_0000_0000_0100;
    issue(mk6(5'b00100, 6'd3), 1, expIb + 64'd24, "R7 pos");
    expPc = expPc + 64'd2; expIb = expIb + 64'h100; chkRegs("R7 ibl pos");
    constVal = -64'sd64;
    issue(mk6(5'b00100, 6'd63), 1, expIb + 64'd504, "R7 neg");
    expPc = expPc + 64'd2; expIb = expIb - 64'd64; chkRegs("R7 ibl neg");
  endtask

  task automatic t_call;
    constVal = {32'h0000_0040, 32'hFFFF_FFE0};
    issue(mk6(5'b00101, 6'd1), 1, expIb + 64'd8, "R8 call");
    expPc = expPc - 64'd32; expIb = expIb + 64'h40; expLink = constVal;
    chkRegs("R8 R11 call");
  endtask

  task automatic t_ret;
    constVal = {32'h0000_0010, 32'h0000_0030};
    issue(mk6(5'b00110, 6'd2), 1, expIb + 64'd16, "R9 ret");
    expPc = expPc + sx(32'h30) - sx(expLink[31:0]);
    expIb = expIb + sx(32'h10) - sx(expLink[63:32]);
    chkRegs("R9 R11 ret");
  endtask

  task automatic t_pin;
    rbData = 64'h1234_5678_0000_0F00;
    raData = 64'hDEAD_0000_0000_8100;
    issue({2'b00, 5'b10100, 3'd0, 3'd1, 3'd2}, 0, '0, "R10 pin");
    expLink = {expIb[31:0] - raData[31:0], expPc[31:0] - rbData[31:0]};
    expPc = expPc + 64'd2;
    chkRegs("R10 pin");
  endtask

  task automatic t_idle;
    @(negedge clk); insValid = 0; insWord = mk9(5'b00001, 9'd100); condFlag = 1;
    repeat (4) @(negedge clk);
    chkRegs("R12 idle");
    chk("R12 rdEn", 64'(cmemRdEn), 64'd0);
  endtask

  task automatic finish;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_jump();
    t_branch();
    t_step();
    t_ibl();
    t_call();
    t_ret();
    t_pin();
    t_idle();
    finish();
  end
endmodule